// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block keeps a 32-bit position for an incremental encoder that drives two inputs, A and B. Both inputs are sampled on the system clock, passed through a two-flop synchronizer and edge-detected. A two-bit source field chooses how the edges become counts. In full x4 quadrature, every edge of either input counts. In step/direction, rising edges of A are counted and the level of B sets the direction. In up-only or down-only mode, A alone is counted, on its rising edges or on both of its edges.

The count wraps at a programmable maximum. Wrapping upward sets a sticky overflow flag and wrapping downward sets a sticky underflow flag. Per-flag enables route these flags onto a summary interrupt output, and software clears the flags through a write-one-to-clear register. A flat register port with a single-cycle write strobe and a combinational read path gives access to the count, the maximum, the decoder control, the run control, the enables, the flags and the clear register.

Register map (word address on `reg_addr`): 0 count, 1 maximum, 2 decoder control, 3 run control, 4 interrupt enable, 5 flags (read-only), 6 clear (write-only, reads 0).

Top module: `qpos_counter`

## Requirements
- R1: After reset the count reads 0, the maximum reads 0xFFFFFFFF, the decoder control, run control, enable and flag registers read 0, and `irq` is low.
- R2: With source field (decoder control bits 15:14) = 0, every change of exactly one input counts once. The count goes up when the new A level differs from the previous B level and down otherwise, so the sequence AB = 00,10,11,01,00 gives +4 and its reverse gives -4.
- R3: In source 0, a sample in which A and B both change is a phase error and leaves the count unchanged.
- R4: With source = 1, a rising edge of A counts up when B is high and down when B is low. Falling edges of A and any change of B alone do not count.
- R5: With source = 2 (up) or 3 (down), only A is counted and changes of B are ignored. Decoder control bit 11 = 1 counts both edges of A, and bit 11 = 0 counts rising edges only.
- R6: No counting happens unless run control bit 3 is set. While it is clear the count holds.
- R7: Counting up from a count equal to the maximum gives 0 and sets overflow flag bit 6.
- R8: Counting down from 0 gives the maximum and sets underflow flag bit 5.
- R9: The flags are sticky. Interrupt-enable bits 6 and 5 gate the matching flags onto `irq`, and an enabled event also sets global flag bit 0. Writing 1s to address 6 at bits 6, 5 and 0 clears those flags.
- R10: A flag set by an event in the same cycle as a clear write of that flag stays set.
- R11: A write to the count register in the same cycle as a count event loads the written value, and the event is lost.
- R12: The maximum, decoder control (bits 15:14 and 11), run control (bit 3) and enables (bits 6 and 5) read back what was written, with all other bits reading 0. The clear register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_a | input | 1 | Encoder input A (asynchronous) |
| enc_b | input | 1 | Encoder input B (asynchronous) |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | High while any enabled overflow/underflow flag is set |

## Verification
An input change applied between two rising edges reaches the count, the flags and `irq` at the third rising edge after it: two synchronizer stages, then one state register. The bench changes inputs on a falling edge, waits exactly three falling edges, and reads at the fourth falling edge. Register writes take effect at the single rising edge under the strobe and are read back on the following falling edge through the combinational read path. For the same-cycle priority cases, the bench raises the write strobe two falling edges after an input change, so that the write and the count event meet at the same rising edge.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  typedef enum logic [1:0] {
    SRC_QUAD    = 2'd0,
    SRC_STEPDIR = 2'd1,
    SRC_UP      = 2'd2,
    SRC_DOWN    = 2'd3
  } src_e;

  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;

  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIMIT = 3'd1;
  localparam logic [ADDR_W-1:0] A_DEC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RUN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd6;

  localparam int SRC_HI   = 15;
  localparam int SRC_LO   = 14;
  localparam int BOTH_BIT = 11;
  localparam int RUN_BIT  = 3;
  localparam int OVF_BIT  = 6;
  localparam int UNF_BIT  = 5;
  localparam int GLB_BIT  = 0;

endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= raw[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign lvl[i] = s2_q;
    assign prv[i] = s3_q;
  end

endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
(
  input  src_e       src,
  input  logic       both_edges,
  input  logic [1:0] lvl,
  input  logic [1:0] prv,
  output logic       step,
  output logic       up
);

  logic a_chg, b_chg, a_rise;

  assign a_chg  = lvl[0] ^ prv[0];
  assign b_chg  = lvl[1] ^ prv[1];
  assign a_rise = lvl[0] & ~prv[0];

  always_comb begin
    step = 1'b0;
    up   = 1'b0;
    unique case (src)
      SRC_QUAD: begin
        step = a_chg ^ b_chg;
        up   = lvl[0] ^ prv[1];
      end
      SRC_STEPDIR: begin
        step = a_rise;
        up   = lvl[1];
      end
      SRC_UP: begin
        step = both_edges ? a_chg : a_rise;
        up   = 1'b1;
      end
      SRC_DOWN: begin
        step = both_edges ? a_chg : a_rise;
        up   = 1'b0;
      end
      default: begin
        step = 1'b0;
        up   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/qpos_core.sv
module qpos_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic         up,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] maxv,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         unf_evt
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         at_max, at_zero, go;

  assign at_max  = (cnt_q == maxv);
  assign at_zero = (cnt_q == ZERO);
  assign go      = run & step & ~ld;

  always_comb begin
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    ovf_evt = 1'b0;
    unf_evt = 1'b0;
    if (ld) begin
      cnt_d  = ld_val;
      cnt_en = 1'b1;
    end else if (go) begin
      cnt_en = 1'b1;
      if (up) begin
        if (at_max) begin
          cnt_d   = ZERO;
          ovf_evt = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (at_zero) begin
          cnt_d   = maxv;
          unf_evt = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R11
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt_q));

  // R7
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && up && !ld && cnt_q == maxv) |=> cnt_q == ZERO);

  // R8
  unf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !up && !ld && cnt_q == ZERO) |=> cnt_q == $past(maxv));

endmodule

// File: rtl/qpos_irq.sv
module qpos_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_evt,
  input  logic       unf_evt,
  input  logic [1:0] ien,
  input  logic       clr_we,
  input  logic [2:0] clr_bits,
  output logic [2:0] flg,
  output logic       irq
);

  logic [2:0] flg_q, flg_d, set_v, clr_v;
  logic       glb_set;

  assign glb_set = (ovf_evt & ien[1]) | (unf_evt & ien[0]);
  assign set_v   = {ovf_evt, unf_evt, glb_set};
  assign clr_v   = clr_we ? clr_bits : 3'b000;

  always_comb begin
    flg_d = (flg_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= 3'b000;
    else        flg_q <= flg_d;
  end

  assign flg = flg_q;
  assign irq = |(flg_q[2:1] & ien);

  // R10
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flg_q[2]);

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[2] && !ovf_evt) |=> !flg_q[2]);

  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[1] && !(clr_we && clr_bits[1])) |=> flg_q[1]);

endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam logic [DATA_W-1:0] MAX_RST = '1;

  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [DATA_W-1:0] max_q, max_d;
  src_e              src_q, src_d;
  logic              both_q, both_d, run_q, run_d;
  logic [1:0]        ien_q, ien_d;
  logic              we_max, we_dec, we_run, we_ien, we_cnt, we_clr;

  assign we_cnt = reg_wr & (reg_addr == A_COUNT);
  assign we_max = reg_wr & (reg_addr == A_LIMIT);
  assign we_dec = reg_wr & (reg_addr == A_DEC);
  assign we_run = reg_wr & (reg_addr == A_RUN);
  assign we_ien = reg_wr & (reg_addr == A_IEN);
  assign we_clr = reg_wr & (reg_addr == A_CLR);

  always_comb begin
    max_d  = max_q;
    src_d  = src_q;
    both_d = both_q;
    run_d  = run_q;
    ien_d  = ien_q;
    if (we_max) max_d = reg_wdata;
    if (we_dec) begin
      src_d  = src_e'(reg_wdata[SRC_HI:SRC_LO]);
      both_d = reg_wdata[BOTH_BIT];
    end
    if (we_run) run_d = reg_wdata[RUN_BIT];
    if (we_ien) ien_d = {reg_wdata[OVF_BIT], reg_wdata[UNF_BIT]};
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      max_q  <= MAX_RST;
      src_q  <= SRC_QUAD;
      both_q <= 1'b0;
      run_q  <= 1'b0;
      ien_q  <= 2'b00;
    end else begin
      max_q  <= max_d;
      src_q  <= src_d;
      both_q <= both_d;
      run_q  <= run_d;
      ien_q  <= ien_d;
    end
  end

  logic [1:0] lvl, prv;
  logic       step, up, ovf_evt, unf_evt;
  logic [DATA_W-1:0] cnt;
  logic [2:0] flg;

  qpos_sync #(.N(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .raw   ({enc_b, enc_a}),
    .lvl   (lvl),
    .prv   (prv)
  );

  qpos_decode u_dec (
    .src        (src_q),
    .both_edges (both_q),
    .lvl        (lvl),
    .prv        (prv),
    .step       (step),
    .up         (up)
  );

  qpos_core #(.W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_q),
    .run     (run_q),
    .step    (step),
    .up      (up),
    .ld      (we_cnt),
    .ld_val  (reg_wdata),
    .maxv    (max_q),
    .cnt     (cnt),
    .ovf_evt (ovf_evt),
    .unf_evt (unf_evt)
  );

  qpos_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_q),
    .ovf_evt  (ovf_evt),
    .unf_evt  (unf_evt),
    .ien      (ien_q),
    .clr_we   (we_clr),
    .clr_bits ({reg_wdata[OVF_BIT], reg_wdata[UNF_BIT], reg_wdata[GLB_BIT]}),
    .flg      (flg),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_COUNT: reg_rdata = cnt;
      A_LIMIT: reg_rdata = max_q;
      A_DEC: begin
        reg_rdata[SRC_HI:SRC_LO] = src_q;
        reg_rdata[BOTH_BIT]      = both_q;
      end
      A_RUN:   reg_rdata[RUN_BIT] = run_q;
      A_IEN: begin
        reg_rdata[OVF_BIT] = ien_q[1];
        reg_rdata[UNF_BIT] = ien_q[0];
      end
      A_FLAG: begin
        reg_rdata[OVF_BIT] = flg[2];
        reg_rdata[UNF_BIT] = flg[1];
        reg_rdata[GLB_BIT] = flg[0];
      end
      default: reg_rdata = '0;
    endcase
  end

  // R3
  phase_err_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (src_q == SRC_QUAD && (lvl[0] != prv[0]) && (lvl[1] != prv[1])) |-> !step);

  // R6
  no_step_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!run_q && !we_cnt) |=> !$changed(cnt));

  // R9
  irq_enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ien_q == 2'b00) |-> !irq);

endmodule

// File: tb/tb_qpos_counter.sv
module tb_qpos_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0;
  logic        enc_b = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qpos_counter dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 count", 3'd0, 32'd0);
    chk_reg("R1 max", 3'd1, 32'hFFFF_FFFF);
    chk_reg("R1 dec", 3'd2, 32'd0);
    chk_reg("R1 run", 3'd3, 32'd0);
    chk_reg("R1 ien", 3'd4, 32'd0);
    chk_reg("R1 flags", 3'd5, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_regs();
    wr(3'd1, 32'h1234_5678); chk_reg("R12 max", 3'd1, 32'h1234_5678);
    wr(3'd2, 32'hFFFF_FFFF); chk_reg("R12 dec", 3'd2, 32'h0000_C800);
    wr(3'd3, 32'hFFFF_FFFF); chk_reg("R12 run", 3'd3, 32'h0000_0008);
    wr(3'd4, 32'hFFFF_FFFF); chk_reg("R12 ien", 3'd4, 32'h0000_0060);
    chk_reg("R12 clr", 3'd6, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF); wr(3'd2, 32'd0); wr(3'd3, 32'd0); wr(3'd4, 32'd0);
  endtask

  task automatic t_enable();
    wr(3'd2, 32'h0000_8000);
    wr(3'd0, 32'd5);
    drive(1'b1, 1'b0);
    chk_reg("R6 hold while off", 3'd0, 32'd5);
    drive(1'b0, 1'b0);
    wr(3'd3, 32'h8);
    drive(1'b1, 1'b0);
    chk_reg("R6 counts when on", 3'd0, 32'd6);
    drive(1'b0, 1'b0);
    chk_reg("R5 falling ignored", 3'd0, 32'd6);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    chk_reg("R5 B ignored", 3'd0, 32'd6);
  endtask

  task automatic t_quad();
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd100);
    drive(1'b1, 1'b0); chk_reg("R2 fwd 1", 3'd0, 32'd101);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0); chk_reg("R2 fwd 4", 3'd0, 32'd104);
    drive(1'b0, 1'b1); chk_reg("R2 rev 1", 3'd0, 32'd103);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0); chk_reg("R2 rev 4", 3'd0, 32'd100);
  endtask

  task automatic t_phase();
    drive(1'b1, 1'b1); chk_reg("R3 both up", 3'd0, 32'd100);
    drive(1'b0, 1'b0); chk_reg("R3 both down", 3'd0, 32'd100);
  endtask

  task automatic t_dir();
    wr(3'd2, 32'h0000_4000);
    drive(1'b0, 1'b1); chk_reg("R4 B alone", 3'd0, 32'd100);
    drive(1'b1, 1'b1); chk_reg("R4 rise B high", 3'd0, 32'd101);
    drive(1'b0, 1'b1); chk_reg("R4 fall", 3'd0, 32'd101);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0); chk_reg("R4 rise B low", 3'd0, 32'd100);
    drive(1'b0, 1'b0);
  endtask

  task automatic t_updown();
    wr(3'd2, 32'h0000_8800);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0); chk_reg("R5 up both edges", 3'd0, 32'd102);
    wr(3'd2, 32'h0000_C000);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0); chk_reg("R5 down rising", 3'd0, 32'd101);
    wr(3'd2, 32'h0000_C800);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0); chk_reg("R5 down both edges", 3'd0, 32'd99);
  endtask

  task automatic t_ovf();
    wr(3'd2, 32'h0000_8000);
    wr(3'd1, 32'd10); wr(3'd0, 32'd10); wr(3'd4, 32'h40);
    drive(1'b1, 1'b0);
    chk_reg("R7 wrap to 0", 3'd0, 32'd0);
    chk_reg("R9 ovf+glb", 3'd5, 32'h41);
    chk("R9 irq high", {31'd0, irq}, 32'd1);
    drive(1'b0, 1'b0);
    chk_reg("R9 sticky", 3'd5, 32'h41);
    wr(3'd6, 32'h41);
    chk_reg("R9 cleared", 3'd5, 32'd0);
    chk("R9 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_unf();
    wr(3'd2, 32'h0000_C000); wr(3'd4, 32'h60); wr(3'd0, 32'd0);
    drive(1'b1, 1'b0);
    chk_reg("R8 wrap to max", 3'd0, 32'd10);
    chk_reg("R8 unf flag", 3'd5, 32'h21);
    chk("R9 irq unf", {31'd0, irq}, 32'd1);
    drive(1'b0, 1'b0);
    wr(3'd6, 32'h21);
  endtask

  task automatic t_noien();
    wr(3'd2, 32'h0000_8000); wr(3'd4, 32'h0); wr(3'd0, 32'd10);
    drive(1'b1, 1'b0);
    chk_reg("R9 flag without enable", 3'd5, 32'h40);
    chk("R9 irq gated", {31'd0, irq}, 32'd0);
    drive(1'b0, 1'b0);
    wr(3'd6, 32'h61);
  endtask

  task automatic t_setwins();
    wr(3'd4, 32'h40); wr(3'd0, 32'd10);
    @(negedge clk); enc_a = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 3'd6; reg_wdata = 32'h41; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk_reg("R10 set beats clear", 3'd5, 32'h41);
    chk("R10 irq", {31'd0, irq}, 32'd1);
    drive(1'b0, 1'b0);
    wr(3'd6, 32'h61);
  endtask

  task automatic t_ldwins();
    wr(3'd0, 32'd5);
    @(negedge clk); enc_a = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 3'd0; reg_wdata = 32'd1000; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk_reg("R11 write beats count", 3'd0, 32'd1000);
    drive(1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_enable();
    t_quad();
    t_phase();
    t_dir();
    t_updown();
    t_ovf();
    t_unf();
    t_noien();
    t_setwins();
    t_ldwins();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule